// File: doc/BRIEF.md
# Two-Dimensional Strided Address Generator

This block produces the beat addresses for the memory-mapped side of a DMA transfer that covers a rectangle. The rectangle is a set of rows. Every row holds the same number of bytes, and each row begins a fixed stride after the start of the row before it. A single start pulse loads the geometry: the base address, the row length minus one, the row count minus one, the stride and a cyclic flag. The block then presents one address per data beat on a valid/ready handshake. Each address advances by the bus width in bytes.

In non-cyclic mode the block gives a one-cycle completion pulse once the last beat of the last row has been accepted, and then returns to idle. In cyclic mode it starts the pattern again at the base address with no new start pulse, and it runs until reset. The most recent address is always available on a separate output.

Top module: `stride_addr_gen`

## Requirements
- R1: While reset is held, and just after it is released, `beat_valid` and `done` are 0 and `cur_addr` is 0.
- R2: In the cycle after an accepted `start`, `beat_valid` is 1 and `beat_addr` equals `cfg_base`. While `beat_ready` is 0, `beat_valid` stays 1 and `beat_addr` does not change.
- R3: Inside one row, each accepted beat advances the address by `BEAT_BYTES`. A row holds (`cfg_xlen_m1`+1)/`BEAT_BYTES` beats.
- R4: The first beat of row k (counting from 0) is at `cfg_base` + k·`cfg_stride`. There are `cfg_ylen_m1`+1 rows.
- R5: With `cfg_ylen_m1` = 0, the transfer is one contiguous run of (`cfg_xlen_m1`+1)/`BEAT_BYTES` beats.
- R6: When `cfg_cyclic` is 0, `done` is 1 for exactly the one cycle after the final beat is accepted. In that cycle `beat_valid` is 0.
- R7: When `cfg_cyclic` is 1, the beat after the last beat of the last row is at `cfg_base` again, and `done` is never raised.
- R8: A `start` pulse that arrives while a transfer is running is ignored. The address sequence in progress continues unchanged.
- R9: `cur_addr` equals `beat_addr` while a beat is offered. After completion it holds the address of the final beat.
- R10: The configuration is captured when `start` is accepted. Changes to the `cfg_*` inputs during a transfer have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (accepted only while idle) |
| cfg_base | input | AW | Base address, aligned to BEAT_BYTES |
| cfg_xlen_m1 | input | LW | Row length in bytes minus one; the length is a multiple of BEAT_BYTES |
| cfg_ylen_m1 | input | LW | Row count minus one |
| cfg_stride | input | AW | Distance between row starts, at least the row length |
| cfg_cyclic | input | 1 | Restart the pattern after the last row |
| beat_valid | output | 1 | A beat address is offered |
| beat_ready | input | 1 | The consumer accepts the offered address |
| beat_addr | output | AW | Address of the offered beat |
| done | output | 1 | One-cycle pulse after the final beat of a non-cyclic transfer |
| cur_addr | output | AW | Most recent beat address |

## Verification
The hardest case to reach is a row turnover and a pattern wrap that happen together with a stalled consumer and a stray start pulse or configuration change in mid-flight. Each of these is harmless on its own and is only a risk in combination. The stimulus sweeps every row length from one to three beats, every row count from one to three, and both a tight and a gapped stride, under three ready patterns that include stalls on row boundaries. Separate runs disturb `start` and the `cfg_*` inputs right after the first beat, and cyclic runs go through the wrap twice.

// File: rtl/stride_addr_gen.sv
module stride_addr_gen #(
  parameter int AW         = 32,
  parameter int LW         = 16,
  parameter int BEAT_BYTES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cfg_base,
  input  logic [LW-1:0] cfg_xlen_m1,
  input  logic [LW-1:0] cfg_ylen_m1,
  input  logic [AW-1:0] cfg_stride,
  input  logic          cfg_cyclic,
  output logic          beat_valid,
  input  logic          beat_ready,
  output logic [AW-1:0] beat_addr,
  output logic          done,
  output logic [AW-1:0] cur_addr
);
  localparam logic [LW:0]   COL_STEP  = (LW+1)'(BEAT_BYTES);
  localparam logic [AW-1:0] ADDR_STEP = AW'(BEAT_BYTES);

  logic          busy_q, done_q, cyc_q;
  logic [AW-1:0] addr_q, row_q, base_q, stride_q;
  logic [LW-1:0] xm1_q, ym1_q, col_q, rown_q;

  logic [LW:0] col_next;
  logic        fire, row_end, last_row;

  assign fire     = busy_q & beat_ready;
  assign col_next = {1'b0, col_q} + COL_STEP;
  assign row_end  = col_next > {1'b0, xm1_q};
  assign last_row = rown_q == ym1_q;

  assign beat_valid = busy_q;
  assign beat_addr  = addr_q;
  assign cur_addr   = addr_q;
  assign done       = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      cyc_q    <= 1'b0;
      addr_q   <= '0;
      row_q    <= '0;
      base_q   <= '0;
      stride_q <= '0;
      xm1_q    <= '0;
      ym1_q    <= '0;
      col_q    <= '0;
      rown_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q   <= 1'b1;
          cyc_q    <= cfg_cyclic;
          base_q   <= cfg_base;
          stride_q <= cfg_stride;
          xm1_q    <= cfg_xlen_m1;
          ym1_q    <= cfg_ylen_m1;
          addr_q   <= cfg_base;
          row_q    <= cfg_base;
          col_q    <= '0;
          rown_q   <= '0;
        end
      end else if (fire) begin
        if (!row_end) begin
          addr_q <= addr_q + ADDR_STEP;
          col_q  <= col_next[LW-1:0];
        end else if (!last_row) begin
          addr_q <= row_q + stride_q;
          row_q  <= row_q + stride_q;
          col_q  <= '0;
          rown_q <= rown_q + 1'b1;
        end else if (cyc_q) begin
          addr_q <= base_q;
          row_q  <= base_q;
          col_q  <= '0;
          rown_q <= '0;
        end else begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // R2: a stalled beat keeps its address and stays offered
  a_r2_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr));

  // R6: completion is a single cycle and never overlaps an offered beat
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !beat_valid);

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: a start during a stalled beat neither aborts nor moves it
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready && start |=> beat_valid && $stable(beat_addr));

  // R9: after completion the last address is retained
  a_r9_hold_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $stable(cur_addr));

  // R7: a cyclic transfer never finishes
  a_r7_no_done_cyclic: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && cyc_q |=> !done);
endmodule

// File: tb/stride_addr_gen_test.sv
module stride_addr_gen_test;
  localparam int AW = 16;
  localparam int LW = 8;
  localparam int BB = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [LW-1:0] cfg_xlen_m1 = '0;
  logic [LW-1:0] cfg_ylen_m1 = '0;
  logic [AW-1:0] cfg_stride = '0;
  logic          cfg_cyclic = 1'b0;
  logic          beat_valid;
  logic          beat_ready = 1'b0;
  logic [AW-1:0] beat_addr;
  logic          done;
  logic [AW-1:0] cur_addr;

  int total = 0;
  int bad = 0;
  int wd = 0;

  always #2.5 clk = ~clk;

  stride_addr_gen #(.AW(AW), .LW(LW), .BEAT_BYTES(BB)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_base(cfg_base),
    .cfg_xlen_m1(cfg_xlen_m1), .cfg_ylen_m1(cfg_ylen_m1), .cfg_stride(cfg_stride),
    .cfg_cyclic(cfg_cyclic), .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_addr(beat_addr), .done(done), .cur_addr(cur_addr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start = 1'b0;
    beat_ready = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(beat_valid == 1'b0, "R1 valid in reset", int'(beat_valid), 0);
    chk(done == 1'b0, "R1 done in reset", int'(done), 0);
    chk(cur_addr == '0, "R1 cur_addr in reset", int'(cur_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(beat_valid == 1'b0 && done == 1'b0, "R1 idle after reset", int'(beat_valid), 0);
  endtask

  task automatic run_xfer(input int bse, input int xb, input int yr, input int strd,
                          input bit cyc, input int pat, input bit disturb);
    int tot_beats = xb * yr;
    int n_exp = cyc ? tot_beats * 2 + 1 : tot_beats;
    int idx = 0;
    int cc = 0;
    int last = 0;
    cfg_base    = AW'(bse);
    cfg_xlen_m1 = LW'(xb * BB - 1);
    cfg_ylen_m1 = LW'(yr - 1);
    cfg_stride  = AW'(strd);
    cfg_cyclic  = cyc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (idx < n_exp && cc < 2000) begin
      case (pat)
        0: beat_ready = 1'b1;
        1: beat_ready = (cc % 2) == 1;
        default: beat_ready = (cc % 3) != 0;
      endcase
      if (disturb && idx == 1) begin
        start = 1'b1;
        cfg_base = 16'h7700;
        cfg_stride = 16'h0004;
        cfg_xlen_m1 = LW'(BB - 1);
        cfg_ylen_m1 = '0;
        cfg_cyclic = ~cyc;
      end else begin
        start = 1'b0;
      end
      #1;
      if (cyc) chk(done == 1'b0, "R7 no done in cyclic", int'(done), 0);
      if (!beat_valid) begin
        chk(1'b0, "R2 valid dropped mid-transfer", 0, 1);
        idx = n_exp;
      end else begin
        int eb = idx % tot_beats;
        int ea = bse + (eb / xb) * strd + (eb % xb) * BB;
        string rq;
        if (disturb) rq = "R8 R10 addr under disturbance";
        else if (cyc && idx >= tot_beats) rq = "R7 wrap addr";
        else if (yr == 1) rq = "R5 linear addr";
        else if (eb % xb == 0) rq = "R4 row start addr";
        else rq = "R3 in-row addr";
        if (idx == 0) rq = "R2 first addr";
        chk(beat_addr == AW'(ea), rq, int'(beat_addr), ea);
        chk(cur_addr == beat_addr, "R9 cur_addr tracks", int'(cur_addr), int'(beat_addr));
        last = ea;
        if (beat_ready) idx++;
      end
      @(negedge clk);
      cc++;
    end
    start = 1'b0;
    beat_ready = 1'b0;
    if (!cyc) begin
      #1;
      chk(done == 1'b1, "R6 done after final beat", int'(done), 1);
      chk(beat_valid == 1'b0, "R6 idle with done", int'(beat_valid), 0);
      @(negedge clk);
      #1;
      chk(done == 1'b0, "R6 done one cycle", int'(done), 0);
      chk(cur_addr == AW'(last), "R9 holds final addr", int'(cur_addr), last);
    end
  endtask

  initial begin
    while (wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    chk(1'b0, "watchdog expired", wd, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    for (int xb = 1; xb <= 3; xb++)
      for (int yr = 1; yr <= 3; yr++)
        for (int s = 0; s < 2; s++)
          for (int pat = 0; pat < 3; pat++) begin
            int strd = (s == 0) ? xb * BB : xb * BB + 12;
            run_xfer(16'h0100 + xb * 16'h40, xb, yr, strd, 1'b0, pat, 1'b0);
            @(negedge clk);
          end
    run_xfer(16'h2000, 2, 3, 16'h0020, 1'b0, 1, 1'b1);
    run_xfer(16'h3000, 3, 2, 16'h0010, 1'b0, 0, 1'b1);
    run_xfer(16'h4000, 2, 2, 16'h0018, 1'b1, 0, 1'b0);
    do_reset();
    run_xfer(16'h5000, 1, 3, 16'h0008, 1'b1, 2, 1'b0);
    do_reset();
    run_xfer(16'h6000, 3, 1, 16'h000C, 1'b1, 1, 1'b1);
    do_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule